// File: doc/BRIEF.md
# Multi-Bit Shift-Register Random Word Generator

This block holds a 64-bit shift register that advances in single-bit steps. Each step builds the new bit from two pairs of adjacent state bits, shifts the register left by one and places the new bit at position 0. A consumer requests between 1 and 32 fresh bits. The block runs that many steps, one per clock, and then presents the low bits of the advanced register, right-aligned in a 32-bit word with all unused upper bits forced to zero. The advanced register is kept, so the next request continues the same sequence.

Software or a neighbouring block can load a 32-bit seed at any time. A seed load clears the upper half of the register. An all-zero seed would freeze the sequence, so in that case a fixed nonzero constant is loaded instead. The block is meant for test-pattern and simulation-grade randomness, not for secrets.

Top module: `lfsr_word_gen`

## Requirements
- R1: After reset, `busy` and `dataValid` are 0, `dataOut` is 0, and the register holds the substitute seed 32'h1ACE_B00C in its low half with zeros above.
- R2: One step forms the new bit as s[5] ^ s[6] ^ s[61] ^ s[62] of the current state s. The step shifts the state left by one and writes the new bit to bit 0.
- R3: A request accepted at a clock edge makes `busy` high for exactly K cycles, where K is the effective count. One step is taken per busy cycle.
- R4: When the last step is taken, `busy` falls and `dataValid` rises for exactly one cycle. `dataOut` then equals bits K-1..0 of the advanced state, with bits 31..K zero. `dataOut` keeps that value until the next result.
- R5: The advanced state is kept. Back-to-back requests continue the sequence where the previous request stopped.
- R6: `seedLoad` writes `seedVal` into state bits 31..0 and clears bits 63..32. A `seedVal` of zero loads 32'h1ACE_B00C instead.
- R7: A request raised while `busy` is high is ignored. It changes neither the running count nor the result, and it produces no further result.
- R8: A requested count of 0 is treated as 1, and any count above 32 is treated as 32.
- R9: `seedLoad` takes priority. It ends a running request without a `dataValid` pulse and without changing `dataOut`, and a request raised in the same cycle is ignored.
- R10: A 32-bit request returns the full low 32 bits of the advanced state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| seedLoad | input | 1 | Load `seedVal` into the register this cycle |
| seedVal | input | 32 | Seed value (zero is replaced by a constant) |
| reqValid | input | 1 | Request strobe, accepted only while idle |
| reqCount | input | 6 | Number of bits wanted, clamped to 1..32 |
| busy | output | 1 | High while steps of a request are being taken |
| dataOut | output | 32 | Right-aligned result word, upper bits zero |
| dataValid | output | 1 | One-cycle pulse when `dataOut` is new |

## Verification
Two operations can land in the same cycle: a seed load and a step of a running request, with a fresh request strobe raised alongside. The bench starts a long request, then raises `seedLoad` and `reqValid` together partway through it. It judges the outcome on three points. `busy` must drop on the next edge. No `dataValid` pulse may follow, and `dataOut` must keep its previous value. Finally, a later 8-bit request must return bits computed from the new seed alone, which proves that the aborted steps and the simultaneous request left no trace.

// File: rtl/lfsr_gen_pkg.sv
package lfsr_gen_pkg;
  localparam int unsigned OUT_W = 32;
  localparam int unsigned CNT_W = $clog2(OUT_W) + 1;

  typedef struct packed {
    logic             loadSeed;
    logic             stepEn;
    logic             capture;
    logic [CNT_W-1:0] outLen;
  } ctrlStrobes_t;
endpackage

// File: rtl/lfsr_gen_ctrl.sv
module lfsr_gen_ctrl
  import lfsr_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             seedLoad,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] reqCount,
  output ctrlStrobes_t     strobes,
  output logic             busy,
  output logic             dataValid
);
  logic             runQ;
  logic [CNT_W-1:0] remainQ;
  logic [CNT_W-1:0] lenQ;
  logic             validQ;
  logic [CNT_W-1:0] clampLen;

  // Force the requested count into the legal range 1..OUT_W.
  always_comb begin
    if (reqCount == '0)
      clampLen = CNT_W'(1);
    else if (reqCount > CNT_W'(OUT_W))
      clampLen = CNT_W'(OUT_W);
    else
      clampLen = reqCount;
  end

  always_comb begin
    strobes.loadSeed = seedLoad;
    strobes.stepEn   = runQ && !seedLoad;
    strobes.capture  = runQ && !seedLoad && (remainQ == CNT_W'(1));
    strobes.outLen   = lenQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      remainQ <= '0;
      lenQ    <= CNT_W'(1);
      validQ  <= 1'b0;
    end else begin
      validQ <= strobes.capture;
      if (seedLoad) begin
        runQ <= 1'b0;
      end else if (runQ) begin
        remainQ <= remainQ - CNT_W'(1);
        if (remainQ == CNT_W'(1))
          runQ <= 1'b0;
      end else if (reqValid) begin
        runQ    <= 1'b1;
        remainQ <= clampLen;
        lenQ    <= clampLen;
      end
    end
  end

  assign busy      = runQ;
  assign dataValid = validQ;
endmodule

// File: rtl/lfsr_gen_dp.sv
module lfsr_gen_dp
  import lfsr_gen_pkg::*;
#(
  parameter int unsigned STATE_W    = 64,
  parameter int unsigned SEED_W     = 32,
  parameter int unsigned TAP_LO     = 5,
  parameter int unsigned TAP_HI     = 61,
  parameter logic [SEED_W-1:0] SUBST_SEED = 32'h1ACE_B00C
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [SEED_W-1:0] seedVal,
  output logic [OUT_W-1:0]  dataOut
);
  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] pairXor;
  logic [STATE_W-1:0] nextState;
  logic [SEED_W-1:0]  seedEff;
  logic [OUT_W-1:0]   outMask;
  logic [OUT_W-1:0]   outQ;

  // Each tap position contributes the XOR of itself and its upper neighbour.
  assign pairXor   = stateQ ^ (stateQ >> 1);
  assign nextState = {stateQ[STATE_W-2:0], pairXor[TAP_LO] ^ pairXor[TAP_HI]};
  assign seedEff   = (seedVal == '0) ? SUBST_SEED : seedVal;

  for (genvar i = 0; i < OUT_W; i++) begin : g_mask
    assign outMask[i] = (CNT_W'(i) < strobes.outLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= STATE_W'(SUBST_SEED);
      outQ   <= '0;
    end else begin
      if (strobes.loadSeed)
        stateQ <= STATE_W'(seedEff);
      else if (strobes.stepEn)
        stateQ <= nextState;
      if (strobes.capture)
        outQ <= nextState[OUT_W-1:0] & outMask;
    end
  end

  assign dataOut = outQ;
endmodule

// File: rtl/lfsr_word_gen.sv
module lfsr_word_gen
  import lfsr_gen_pkg::*;
#(
  parameter logic [31:0] SUBST_SEED = 32'h1ACE_B00C
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        seedLoad,
  input  logic [31:0] seedVal,
  input  logic        reqValid,
  input  logic [5:0]  reqCount,
  output logic        busy,
  output logic [31:0] dataOut,
  output logic        dataValid
);
  ctrlStrobes_t strobes;

  lfsr_gen_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .seedLoad  (seedLoad),
    .reqValid  (reqValid),
    .reqCount  (reqCount),
    .strobes   (strobes),
    .busy      (busy),
    .dataValid (dataValid)
  );

  lfsr_gen_dp #(
    .STATE_W    (64),
    .SEED_W     (32),
    .TAP_LO     (5),
    .TAP_HI     (61),
    .SUBST_SEED (SUBST_SEED)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .seedVal (seedVal),
    .dataOut (dataOut)
  );
endmodule

// File: rtl/lfsr_word_gen_chk.sv
module lfsr_word_gen_chk (
  input logic        clk,
  input logic        rstN,
  input logic        seedLoad,
  input logic        reqValid,
  input logic        busy,
  input logic [31:0] dataOut,
  input logic        dataValid
);
  // R4
  valid_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && dataValid));
  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);
  // R3
  valid_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> $past(busy));
  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> $stable(dataOut));
  // R9
  seed_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    seedLoad |=> (!busy && !dataValid));
  // R3
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && !seedLoad) |=> busy);
endmodule

bind lfsr_word_gen lfsr_word_gen_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .seedLoad  (seedLoad),
  .reqValid  (reqValid),
  .busy      (busy),
  .dataOut   (dataOut),
  .dataValid (dataValid)
);

// File: tb/lfsr_word_gen_tb.sv
module lfsr_word_gen_tb;
  localparam logic [31:0] SUBST = 32'h1ACE_B00C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        seedLoad = 1'b0;
  logic [31:0] seedVal = '0;
  logic        reqValid = 1'b0;
  logic [5:0]  reqCount = '0;
  logic        busy;
  logic [31:0] dataOut;
  logic        dataValid;

  int unsigned nChecks = 0;
  int unsigned nFails  = 0;
  logic [63:0] mdl;

  always #10 clk = ~clk;

  lfsr_word_gen u_dut (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .seedVal(seedVal),
    .reqValid(reqValid), .reqCount(reqCount), .busy(busy),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  function automatic logic [63:0] stepMdl(input logic [63:0] s);
    logic nb;
    nb = s[5] ^ s[6] ^ s[61] ^ s[62];
    return {s[62:0], nb};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadSeed(input logic [31:0] v);
    @(negedge clk);
    seedLoad = 1'b1; seedVal = v;
    @(negedge clk);
    seedLoad = 1'b0;
    mdl = {32'h0, (v == 0) ? SUBST : v};
    check(!busy && !dataValid, "R6 idle after load", {62'h0, busy, dataValid}, 64'h0);
  endtask

  // Issue a request and check busy length, the valid pulse and the word.
  task automatic runReq(input logic [5:0] k, input int kEff, input string tag);
    int cnt;
    logic [63:0] mask;
    @(negedge clk);
    reqValid = 1'b1; reqCount = k;
    @(negedge clk);
    reqValid = 1'b0;
    cnt = 0;
    while (busy && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    for (int i = 0; i < kEff; i++) mdl = stepMdl(mdl);
    mask = (64'd1 << kEff) - 64'd1;
    check(cnt == kEff, {tag, " busy cycles (R3)"}, 64'(cnt), 64'(kEff));
    check(dataValid == 1'b1, {tag, " valid pulse (R4)"}, 64'(dataValid), 64'h1);
    check(dataOut == 32'(mdl & mask), {tag, " data (R2/R4)"}, 64'(dataOut), mdl & mask);
    @(negedge clk);
    check(dataValid == 1'b0, {tag, " valid single cycle (R4)"}, 64'(dataValid), 64'h0);
  endtask

  task automatic testReset();
    check(!busy && !dataValid && dataOut == 0, "R1 reset outputs",
          {31'h0, busy, dataOut}, 64'h0);
    mdl = {32'h0, SUBST};
    runReq(6'd16, 16, "R1 first from substitute state");
  endtask

  task automatic testSequence();
    loadSeed(32'hDEAD_BEEF);
    runReq(6'd1, 1, "R2 single step");
    runReq(6'd7, 7, "R5 continue 7");
    runReq(6'd32, 32, "R10 full word");
    runReq(6'd32, 32, "R5 second full word");
    loadSeed(32'h8000_0001);
    for (int i = 0; i < 6; i++) runReq(6'd31, 31, "R5 run 31");
  endtask

  task automatic testClamp();
    loadSeed(32'h1234_5678);
    runReq(6'd0, 1, "R8 zero count");
    runReq(6'd33, 32, "R8 count 33");
    runReq(6'd63, 32, "R8 count 63");
  endtask

  task automatic testZeroSeed();
    loadSeed(32'h0);
    runReq(6'd20, 20, "R6 zero seed substitute");
  endtask

  task automatic testBusyIgnore();
    int cnt;
    logic [63:0] mask;
    loadSeed(32'h0BAD_F00D);
    @(negedge clk);
    reqValid = 1'b1; reqCount = 6'd10;
    @(negedge clk);
    reqValid = 1'b0;
    cnt = 0;
    while (busy && cnt < 100) begin
      cnt++;
      if (cnt == 3) begin reqValid = 1'b1; reqCount = 6'd5; end
      else reqValid = 1'b0;
      @(negedge clk);
    end
    reqValid = 1'b0;
    for (int i = 0; i < 10; i++) mdl = stepMdl(mdl);
    mask = (64'd1 << 10) - 64'd1;
    check(cnt == 10, "R7 busy length unchanged", 64'(cnt), 64'd10);
    check(dataOut == 32'(mdl & mask), "R7 result unchanged", 64'(dataOut), mdl & mask);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (dataValid || busy) cnt++;
    end
    check(cnt == 0, "R7 no extra result", 64'(cnt), 64'h0);
  endtask

  task automatic testAbort();
    logic [31:0] held;
    int cnt;
    held = dataOut;
    @(negedge clk);
    reqValid = 1'b1; reqCount = 6'd20;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    seedLoad = 1'b1; seedVal = 32'hCAFE_0042; reqValid = 1'b1; reqCount = 6'd4;
    @(negedge clk);
    seedLoad = 1'b0; reqValid = 1'b0;
    mdl = {32'h0, 32'hCAFE_0042};
    check(!busy, "R9 busy dropped", 64'(busy), 64'h0);
    cnt = 0;
    for (int i = 0; i < 25; i++) begin
      if (dataValid || busy) cnt++;
      @(negedge clk);
    end
    check(cnt == 0, "R9 no result after abort", 64'(cnt), 64'h0);
    check(dataOut == held, "R9 output held", 64'(dataOut), 64'(held));
    runReq(6'd8, 8, "R9 sequence from new seed");
  endtask

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog R3 actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSequence();
    testClamp();
    testZeroSeed();
    testBusyIgnore();
    testAbort();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule